// File: doc/BRIEF.md
# MSI and INTx Interrupt Aggregator

This block gathers message-signalled interrupts and four legacy level interrupts into small status registers, masks them with per-bit enables and drives one registered interrupt line per source group toward a CPU-side interrupt controller. There are 32 MSI vectors, spread over 8 groups of 4 bits. Vector `v` lands in group `v mod 8`, bit `v / 8`. Each of the 4 legacy lines owns a one-bit group of its own.

A vector is raised in one of two ways. The message-decode logic can pulse `msi_stb` with a vector number. Software can also write a vector number to the MSI target register. Software reads status and acknowledges bits by writing ones to them. It sets or clears enable bits through separate set and clear addresses. When it has finished with a group, it writes that group's identifier to the end-of-interrupt (EOI) register. The group output then drops. It comes back on its own if enabled bits are still pending.

The MSI groups and the legacy lines use one shared EOI numbering: legacy line `n` is `n`, and MSI group `g` is `g + 4`.

Top module: `irq_aggregator`

## Requirements
- R1: A pulse on `msi_stb` with vector `v` sets bit `v/8` of MSI group `v mod 8` status. The status of group `g` reads at offset 0x104 + 0x10*g, in bits [3:0].
- R2: A bus write to offset 0x054 raises the vector held in the low 5 bits of the write data, exactly as R1 does. Higher data bits are ignored.
- R3: Writing a 1 to a status bit clears it, for MSI groups and for legacy lines alike. Bits written as 0 are unchanged.
- R4: A write to enable-set (status offset + 4) sets only the bits written as 1. A write to enable-clear (status offset + 8) clears only the bits written as 1. A read of either address returns the current enable mask.
- R5: A group output is high when (status AND enable) is non-zero and the group is armed. The output register updates on the clock edge after the state that feeds it.
- R6: A status bit is recorded even while its enable is 0. Its output stays low.
- R7: Writing `g + 4` to the EOI register at 0x050 drops MSI group `g`'s output at that same edge and disarms the group for one cycle. If enabled bits are still pending, the output returns two edges after the EOI write. Other groups are unaffected.
- R8: Legacy line `n` uses status/enable-set/enable-clear at 0x184/0x188/0x18C + 0x10*n, in bit 0. A high input level sets the status. Its output is the bit at `intx_irq[n]`. Writing `n` to the EOI register acknowledges it, with the same timing as R7.
- R9: When a raise (MSI vector or high legacy level) and a write-one-to-clear hit the same status bit in one cycle, the bit stays set.
- R10: Reset (synchronous, active high) clears all status and enable bits, drives every output low and arms every group.
- R11: `bus_rdata` holds the register selected by `bus_addr`, loaded one edge after `bus_rd` is high, and keeps that value until the next read. Unmapped offsets, including 0x050 and 0x054, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| msi_stb | input | 1 | MSI raise strobe |
| msi_vec | input | 5 | MSI vector number |
| intx_lvl | input | 4 | Legacy interrupt levels, synchronous to clk |
| msi_irq | output | 8 | Per-group MSI interrupt outputs |
| intx_irq | output | 4 | Per-line legacy interrupt outputs |

## Verification
Status and enable registers change at the edge that samples the stimulus. The bench therefore reads them back with a read strobe one cycle later, and that data is compared on the next falling edge. A group output lags the state it depends on by one edge, so after raising a bit or changing an enable the bench inserts one idle cycle before sampling the outputs. After an EOI write, the outputs are sampled at three points: right after the EOI edge, where the output must be low; one edge later, where it must still be low because the group is disarmed; and two edges later, where a still-pending group must fire again. Every sample is taken on the falling clock edge, half a period away from the edge that updates the registers.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // register offsets (byte addresses)
  localparam int OFS_EOI       = 32'h050;
  localparam int OFS_MSI_TGT   = 32'h054;
  localparam int OFS_MSI_STAT  = 32'h104;
  localparam int OFS_INTX_STAT = 32'h184;
  localparam int OFS_STRIDE    = 32'h010;
  // enable-set / enable-clear sit after the status word
  localparam int OFS_ENA_SET   = 4;
  localparam int OFS_ENA_CLR   = 8;
endpackage

// File: rtl/irqc_src_group.sv
module irqc_src_group
  import irqc_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int BITS = 4,
  parameter logic [AW-1:0] BASE = '0,
  parameter int EOI_ID = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [BITS-1:0] set_i,
  output logic            rd_hit,
  output logic [DW-1:0]   rd_data,
  output logic            irq_o
);
  localparam logic [AW-1:0] A_STAT = BASE;
  localparam logic [AW-1:0] A_ESET = BASE + AW'(OFS_ENA_SET);
  localparam logic [AW-1:0] A_ECLR = BASE + AW'(OFS_ENA_CLR);
  localparam logic [AW-1:0] A_EOI  = AW'(OFS_EOI);
  localparam logic [DW-1:0] EOI_VAL = DW'(EOI_ID);

  logic [BITS-1:0] stat_q, en_q, stat_n, en_n, clr_m;
  logic            armed_q, irq_q;
  logic            wr_stat, wr_eset, wr_eclr, eoi;

  assign wr_stat = wr && (addr == A_STAT);
  assign wr_eset = wr && (addr == A_ESET);
  assign wr_eclr = wr && (addr == A_ECLR);
  assign eoi     = wr && (addr == A_EOI) && (wdata == EOI_VAL);

  // raise beats clear on the same bit
  assign clr_m  = wr_stat ? wdata[BITS-1:0] : '0;
  assign stat_n = (stat_q & ~clr_m) | set_i;

  always_comb begin
    en_n = en_q;
    if (wr_eset) en_n = en_q | wdata[BITS-1:0];
    if (wr_eclr) en_n = en_q & ~wdata[BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      en_q    <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      stat_q  <= stat_n;
      en_q    <= en_n;
      armed_q <= !eoi;
      irq_q   <= (|(stat_q & en_q)) && armed_q && !eoi;
    end
  end

  assign irq_o  = irq_q;
  assign rd_hit = (addr == A_STAT) || (addr == A_ESET) || (addr == A_ECLR);

  always_comb begin
    rd_data = '0;
    if (addr == A_STAT)
      rd_data[BITS-1:0] = stat_q;
    else if ((addr == A_ESET) || (addr == A_ECLR))
      rd_data[BITS-1:0] = en_q;
  end

  AST_RAISE_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i))); // R9
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_stat |=> ((stat_q & $past(wdata[BITS-1:0] & ~set_i)) == '0)); // R3
  AST_ENA_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_eset && !wr_eclr) |=> ((en_q & $past(wdata[BITS-1:0])) == $past(wdata[BITS-1:0]))); // R4
  AST_ENA_CLR: assert property (@(posedge clk) disable iff (rst)
    wr_eclr |=> ((en_q & $past(wdata[BITS-1:0])) == '0)); // R4
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & en_q) == '0) |=> !irq_o); // R6
  AST_EOI_DROP: assert property (@(posedge clk) disable iff (rst)
    eoi |=> !irq_o); // R7
  AST_EOI_HOLD: assert property (@(posedge clk) disable iff (rst)
    eoi |=> ##1 !irq_o); // R7
endmodule

// File: rtl/irqc_vec_decode.sv
module irqc_vec_decode
  import irqc_pkg::*;
#(
  parameter int NUM_GRP = 8,
  parameter int BITS = 4,
  parameter int AW = 12,
  localparam int VEC_W = $clog2(NUM_GRP * BITS),
  localparam int GRP_W = $clog2(NUM_GRP)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           msi_stb,
  input  logic [VEC_W-1:0]               msi_vec,
  input  logic                           wr,
  input  logic [AW-1:0]                  addr,
  input  logic [VEC_W-1:0]               tgt_vec,
  output logic [NUM_GRP-1:0][BITS-1:0]   set_o
);
  localparam logic [AW-1:0] A_TGT = AW'(OFS_MSI_TGT);

  logic tgt_hit;
  assign tgt_hit = wr && (addr == A_TGT);

  // group from the low vector bits, bit position from the high ones
  always_comb begin
    set_o = '0;
    if (msi_stb)
      set_o[msi_vec[GRP_W-1:0]][msi_vec[VEC_W-1:GRP_W]] = 1'b1;
    if (tgt_hit)
      set_o[tgt_vec[GRP_W-1:0]][tgt_vec[VEC_W-1:GRP_W]] = 1'b1;
  end

  AST_PORT_ONE_RAISE: assert property (@(posedge clk) disable iff (rst)
    (msi_stb && !tgt_hit) |-> ($countones(set_o) == 1)); // R1
  AST_TGT_ONE_RAISE: assert property (@(posedge clk) disable iff (rst)
    (tgt_hit && !msi_stb) |-> ($countones(set_o) == 1)); // R2
  AST_IDLE_NO_RAISE: assert property (@(posedge clk) disable iff (rst)
    (!tgt_hit && !msi_stb) |-> (set_o == '0)); // R1
endmodule

// File: rtl/irqc_rd_merge.sv
module irqc_rd_merge #(
  parameter int N = 12,
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd,
  input  logic [N-1:0]           hit_i,
  input  logic [N-1:0][DW-1:0]   data_i,
  output logic [DW-1:0]          rdata_o
);
  logic [DW-1:0] merged;
  logic [DW-1:0] rdata_q;

  always_comb begin
    merged = '0;
    for (int i = 0; i < N; i++)
      if (hit_i[i]) merged = merged | data_i[i];
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= merged;
  end

  assign rdata_o = rdata_q;

  AST_ONE_DECODE: assert property (@(posedge clk) disable iff (rst)
    rd |-> $onehot0(hit_i)); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata_o)); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && (hit_i == '0)) |=> (rdata_o == '0)); // R11
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqc_pkg::*;
#(
  parameter int NUM_GRP = 8,
  parameter int GRP_BITS = 4,
  parameter int NUM_INTX = 4,
  parameter int AW = 12,
  parameter int DW = 32,
  localparam int VEC_W = $clog2(NUM_GRP * GRP_BITS),
  localparam int NSRC = NUM_GRP + NUM_INTX
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic                msi_stb,
  input  logic [VEC_W-1:0]    msi_vec,
  input  logic [NUM_INTX-1:0] intx_lvl,
  output logic [NUM_GRP-1:0]  msi_irq,
  output logic [NUM_INTX-1:0] intx_irq
);
  logic [NUM_GRP-1:0][GRP_BITS-1:0] msi_set;
  logic [NSRC-1:0]                  hit;
  logic [NSRC-1:0][DW-1:0]          rdat;

  irqc_vec_decode #(
    .NUM_GRP(NUM_GRP), .BITS(GRP_BITS), .AW(AW)
  ) u_dec (
    .clk(clk), .rst(rst), .msi_stb(msi_stb), .msi_vec(msi_vec),
    .wr(bus_wr), .addr(bus_addr), .tgt_vec(bus_wdata[VEC_W-1:0]),
    .set_o(msi_set)
  );

  // MSI groups: EOI numbers follow the legacy lines
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_msi
    localparam logic [AW-1:0] GBASE = AW'(OFS_MSI_STAT + g * OFS_STRIDE);
    irqc_src_group #(
      .AW(AW), .DW(DW), .BITS(GRP_BITS), .BASE(GBASE), .EOI_ID(NUM_INTX + g)
    ) u_grp (
      .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .set_i(msi_set[g]), .rd_hit(hit[g]), .rd_data(rdat[g]), .irq_o(msi_irq[g])
    );
  end

  for (genvar n = 0; n < NUM_INTX; n++) begin : g_intx
    localparam logic [AW-1:0] LBASE = AW'(OFS_INTX_STAT + n * OFS_STRIDE);
    irqc_src_group #(
      .AW(AW), .DW(DW), .BITS(1), .BASE(LBASE), .EOI_ID(n)
    ) u_line (
      .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .set_i(intx_lvl[n]), .rd_hit(hit[NUM_GRP+n]), .rd_data(rdat[NUM_GRP+n]),
      .irq_o(intx_irq[n])
    );
  end

  irqc_rd_merge #(.N(NSRC), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .hit_i(hit), .data_i(rdat),
    .rdata_o(bus_rdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (msi_irq == '0 && intx_irq == '0)); // R10
endmodule

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;
  localparam logic [3:0] OP_WR = 4'd0, OP_RD = 4'd1, OP_MSI = 4'd2,
                         OP_IRQ = 4'd3, OP_IDLE = 4'd4, OP_LVL = 4'd5;
  localparam int NSTEP = 64;
  localparam int WDOG_LIMIT = 200000;

  // {requirement, op, addr, data}
  localparam logic [51:0] TBL [NSTEP] = '{
    {4'd10, OP_RD,   12'h104, 32'h0},   // R10 status zero
    {4'd10, OP_IRQ,  12'h000, 32'h0},   // R10 outputs low
    {4'd1,  OP_MSI,  12'h000, 32'd9},   // R1 vector 9 -> group 1 bit 1
    {4'd1,  OP_RD,   12'h114, 32'h2},   // R1
    {4'd6,  OP_IRQ,  12'h000, 32'h0},   // R6 masked
    {4'd4,  OP_WR,   12'h118, 32'h2},   // R4 enable bit 1
    {4'd5,  OP_IDLE, 12'h000, 32'h0},
    {4'd5,  OP_IRQ,  12'h000, 32'h002}, // R5 group 1 fires
    {4'd4,  OP_RD,   12'h11C, 32'h2},   // R4 read at clear address
    {4'd4,  OP_RD,   12'h118, 32'h2},   // R4 read at set address
    {4'd7,  OP_WR,   12'h050, 32'd5},   // R7 EOI group 1
    {4'd7,  OP_IRQ,  12'h000, 32'h0},   // R7 dropped
    {4'd7,  OP_IDLE, 12'h000, 32'h0},
    {4'd7,  OP_IRQ,  12'h000, 32'h0},   // R7 disarmed
    {4'd7,  OP_IDLE, 12'h000, 32'h0},
    {4'd7,  OP_IRQ,  12'h000, 32'h002}, // R7 re-fires
    {4'd3,  OP_WR,   12'h114, 32'h2},   // R3 clear bit 1
    {4'd3,  OP_IDLE, 12'h000, 32'h0},
    {4'd3,  OP_IRQ,  12'h000, 32'h0},   // R3
    {4'd3,  OP_RD,   12'h114, 32'h0},   // R3
    {4'd2,  OP_WR,   12'h054, 32'hFF},  // R2 low bits = 31
    {4'd2,  OP_RD,   12'h174, 32'h8},   // R2 group 7 bit 3
    {4'd1,  OP_MSI,  12'h000, 32'd0},   // R1
    {4'd1,  OP_MSI,  12'h000, 32'd24},  // R1
    {4'd1,  OP_RD,   12'h104, 32'h9},   // R1 vectors 0 and 24
    {4'd3,  OP_WR,   12'h104, 32'h1},   // R3 clear only bit 0
    {4'd3,  OP_RD,   12'h104, 32'h8},   // R3
    {4'd4,  OP_WR,   12'h108, 32'h5},   // R4
    {4'd4,  OP_RD,   12'h10C, 32'h5},   // R4
    {4'd4,  OP_WR,   12'h10C, 32'h4},   // R4 clear only bit 2
    {4'd4,  OP_RD,   12'h108, 32'h1},   // R4
    {4'd6,  OP_IDLE, 12'h000, 32'h0},
    {4'd6,  OP_IRQ,  12'h000, 32'h0},   // R6 pending but masked
    {4'd6,  OP_RD,   12'h174, 32'h8},   // R6 still latched
    {4'd7,  OP_WR,   12'h178, 32'h8},   // R7 enable group 7
    {4'd7,  OP_IDLE, 12'h000, 32'h0},
    {4'd7,  OP_IRQ,  12'h000, 32'h080}, // R5/R7
    {4'd7,  OP_WR,   12'h050, 32'd4},   // R7 EOI group 0 only
    {4'd7,  OP_IRQ,  12'h000, 32'h080}, // R7 group 7 untouched
    {4'd7,  OP_IDLE, 12'h000, 32'h0},
    {4'd7,  OP_IRQ,  12'h000, 32'h080}, // R7
    {4'd3,  OP_WR,   12'h174, 32'h8},   // R3
    {4'd3,  OP_IDLE, 12'h000, 32'h0},
    {4'd3,  OP_IRQ,  12'h000, 32'h0},   // R3
    {4'd8,  OP_LVL,  12'h000, 32'h4},   // R8 line 2 high
    {4'd8,  OP_LVL,  12'h000, 32'h0},   // R8
    {4'd8,  OP_RD,   12'h1A4, 32'h1},   // R8 latched
    {4'd8,  OP_IRQ,  12'h000, 32'h0},   // R8 masked
    {4'd8,  OP_WR,   12'h1A8, 32'h1},   // R8 enable
    {4'd8,  OP_IDLE, 12'h000, 32'h0},
    {4'd8,  OP_IRQ,  12'h000, 32'h400}, // R8 intx_irq[2]
    {4'd8,  OP_RD,   12'h1AC, 32'h1},   // R8
    {4'd8,  OP_WR,   12'h050, 32'd2},   // R8 EOI line 2
    {4'd8,  OP_IRQ,  12'h000, 32'h0},   // R8
    {4'd8,  OP_IDLE, 12'h000, 32'h0},
    {4'd8,  OP_IDLE, 12'h000, 32'h0},
    {4'd8,  OP_IRQ,  12'h000, 32'h400}, // R8 re-fires
    {4'd8,  OP_WR,   12'h1A4, 32'h1},   // R8/R3
    {4'd8,  OP_IDLE, 12'h000, 32'h0},
    {4'd8,  OP_IRQ,  12'h000, 32'h0},   // R8
    {4'd8,  OP_RD,   12'h1A4, 32'h0},   // R8
    {4'd11, OP_RD,   12'h300, 32'h0},   // R11 unmapped
    {4'd11, OP_RD,   12'h050, 32'h0},   // R11 EOI reads zero
    {4'd11, OP_RD,   12'h054, 32'h0}    // R11 target reads zero
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        msi_stb = 1'b0;
  logic [4:0]  msi_vec = '0;
  logic [3:0]  intx_lvl = '0;
  logic [7:0]  msi_irq;
  logic [3:0]  intx_irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_aggregator dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .msi_stb(msi_stb), .msi_vec(msi_vec), .intx_lvl(intx_lvl),
    .msi_irq(msi_irq), .intx_irq(intx_irq)
  );

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input int req, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic do_msi(input logic [4:0] v);
    msi_vec = v; msi_stb = 1'b1;
    @(negedge clk);
    msi_stb = 1'b0;
  endtask

  task automatic chk_irq(input int req, input logic [11:0] exp);
    chk(req, {20'h0, intx_irq, msi_irq}, {20'h0, exp});
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WDOG_LIMIT && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got cycle %0d expected below %0d", cyc, WDOG_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NSTEP; i++) begin
      logic [3:0]  req;
      logic [3:0]  op;
      logic [11:0] a;
      logic [31:0] d;
      {req, op, a, d} = TBL[i];
      case (op)
        OP_WR:   do_wr(a, d);
        OP_RD:   do_rd(int'(req), a, d);
        OP_MSI:  do_msi(d[4:0]);
        OP_IRQ:  chk_irq(int'(req), d[11:0]);
        OP_LVL:  begin intx_lvl = d[3:0]; @(negedge clk); end
        default: @(negedge clk);
      endcase
    end

    // R9: raise and clear of the same bit in one cycle; group 0 holds 0x8
    do_msi(5'd8);
    msi_vec = 5'd8; msi_stb = 1'b1;
    bus_addr = 12'h104; bus_wdata = 32'hA; bus_wr = 1'b1;
    @(negedge clk);
    msi_stb = 1'b0; bus_wr = 1'b0;
    do_rd(9, 12'h104, 32'h2); // R9 bit 1 kept, bit 3 cleared

    // R9: legacy level held high against a clear
    intx_lvl = 4'b0010;
    @(negedge clk);
    do_wr(12'h194, 32'h1);
    do_rd(9, 12'h194, 32'h1); // R9
    intx_lvl = 4'b0000;
    do_wr(12'h194, 32'h1);
    do_rd(3, 12'h194, 32'h0); // R3

    // R10: reset in the middle of activity
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk_irq(10, 12'h000);       // R10
    do_rd(10, 12'h108, 32'h0);  // R10 enables cleared
    do_rd(10, 12'h104, 32'h0);  // R10 status cleared
    // R10: armed after reset, fires without an EOI
    do_msi(5'd3);
    do_wr(12'h138, 32'h1);
    @(negedge clk);
    chk_irq(10, 12'h008);       // R10/R5

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule